// File: doc/BRIEF.md
# Timebase Sample Pacer with Scan Timeout

This block paces the sample strobes of an acquisition engine. A 4-bit timebase index picks one of sixteen settings. Each setting fixes a pacing mode and a scan-timeout period. There are three pacing modes. The first strobes on every clock while a scan runs. The second strobes whenever the converters report a finished conversion. The third waits for a finished conversion and then holds off for a programmed number of quarter-microseconds before it can strobe again.

A scan starts with a one-cycle start pulse and stays active on `keep_sampling` until something ends it. Four things end a scan: an external abort, a change of timebase index, a change of trigger polarity, or expiry of the timeout timer. The timer is armed only when the scan starts with timeout enabled. It counts milliseconds derived from a tick prescaler, and on expiry it emits a one-cycle `timeout_evt` and stops the scan. Once the acquisition logic has accepted a trigger, the hold-off countdown is skipped, so post-trigger samples follow conversion completion directly.

Top module: `timebase_pacer`

## Requirements
- R1: After reset, `keep_sampling`, `sample_stb` and `timeout_evt` are all 0.
- R2: A start pulse with no abort and no reconfiguration sets `keep_sampling` in the next cycle and latches the timebase index for the scan. A start during a running scan reloads the timeout timer.
- R3: `abort` clears `keep_sampling` in the next cycle and takes priority over a simultaneous start.
- R4: Any change of `tb_sel` or `trig_pol` clears `keep_sampling` in the next cycle and stops the timeout timer, so no `timeout_evt` follows.
- R5: Index 0 is free-running: while the scan runs, `sample_stb` is 1 in every cycle regardless of `conv_ready`.
- R6: Indices 12 to 15 are conversion-paced with no hold-off: while the scan runs, `sample_stb` equals `conv_ready` in every cycle.
- R7: Indices 1 to 11 carry hold-offs of 3, 14, 33, 81, 178, 465, 946, 1910, 4776, 9570 and 19163 quarter-microseconds, in that index order. With `conv_ready` held high, consecutive strobes are D*CYC_PER_QUS+1 cycles apart, where D is the hold-off.
- R8: While `trig_locked` is 1, any remaining hold-off is dropped at the next clock edge and no new hold-off is loaded, so strobes follow `conv_ready`.
- R9: Timeout periods in ms are 50, 50, 50, 100, 100, 100, 150, 250, 500, 1000, 2000 and 4500 for indices 0 to 11, and 50 for indices 12 to 15. With timeout enabled, `keep_sampling` falls exactly T*TICK_DIV cycles after the start edge. `timeout_evt` is 1 for exactly that one cycle.
- R10: A scan started with `to_en` low never times out.
- R11: `sample_stb` is 1 only while `keep_sampling` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tb_sel | input | 4 | Timebase index |
| trig_pol | input | 1 | Trigger polarity; any change aborts the scan |
| start | input | 1 | One-cycle scan start |
| to_en | input | 1 | Arm the timeout timer at start |
| conv_ready | input | 1 | Both converters report end of conversion |
| trig_locked | input | 1 | Trigger already accepted for this scan |
| abort | input | 1 | External scan abort |
| sample_stb | output | 1 | Take a sample this cycle |
| keep_sampling | output | 1 | Scan active |
| timeout_evt | output | 1 | One-cycle timeout expiry pulse |

## Verification
The assertions check the relations that hold on every cycle:
- strobes never appear outside a scan;
- abort and reconfiguration end the scan on the next edge;
- a clean start raises `keep_sampling`;
- the timeout pulse lasts one cycle and coincides with the scan ending.

Some behaviours can only be shown by the bench's scenarios. These are the exact strobe spacing of every timebase entry, the exact timeout length of every index, the skipping of the hold-off after a trigger, and the absence of a timeout after reconfiguration or with the timer disarmed.

// File: rtl/timebase_pacer.sv
module timebase_pacer #(
  parameter int CYC_PER_QUS = 25,
  parameter int TICK_DIV    = 100000,
  localparam int MAX_QUS    = 19163,
  localparam int DW         = $clog2(MAX_QUS * CYC_PER_QUS + 1),
  localparam int TW         = $clog2(TICK_DIV + 1),
  localparam int MW         = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] tb_sel,
  input  logic       trig_pol,
  input  logic       start,
  input  logic       to_en,
  input  logic       conv_ready,
  input  logic       trig_locked,
  input  logic       abort,
  output logic       sample_stb,
  output logic       keep_sampling,
  output logic       timeout_evt
);

  function automatic int qus_of(input logic [3:0] i);
    case (i)
      4'd0:    return -1;
      4'd1:    return 3;
      4'd2:    return 14;
      4'd3:    return 33;
      4'd4:    return 81;
      4'd5:    return 178;
      4'd6:    return 465;
      4'd7:    return 946;
      4'd8:    return 1910;
      4'd9:    return 4776;
      4'd10:   return 9570;
      4'd11:   return 19163;
      default: return 0;
    endcase
  endfunction

  function automatic int ms_of(input logic [3:0] i);
    case (i)
      4'd3, 4'd4, 4'd5: return 100;
      4'd6:    return 150;
      4'd7:    return 250;
      4'd8:    return 500;
      4'd9:    return 1000;
      4'd10:   return 2000;
      4'd11:   return 4500;
      default: return 50;
    endcase
  endfunction

  logic [3:0]    tb_q, idx_q;
  logic          pol_q, run, to_on, evt;
  logic [DW-1:0] dly_cnt;
  logic [TW-1:0] tick;
  logic [MW-1:0] ms_left;

  int qd;
  assign qd = qus_of(idx_q);

  logic free_run, kill, tick_wrap, expire;
  assign free_run   = (qd < 0);
  assign kill       = abort | (tb_sel != tb_q) | (trig_pol != pol_q);
  assign tick_wrap  = (tick == TW'(TICK_DIV - 1));
  assign expire     = to_on & tick_wrap & (ms_left == MW'(1));
  assign sample_stb = run & (dly_cnt == '0) & (free_run | conv_ready);

  assign keep_sampling = run;
  assign timeout_evt   = evt;

  always_ff @(posedge clk) begin
    tb_q  <= tb_sel;
    pol_q <= trig_pol;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      to_on   <= 1'b0;
      evt     <= 1'b0;
      idx_q   <= '0;
      dly_cnt <= '0;
      tick    <= '0;
      ms_left <= '0;
    end else begin
      evt <= 1'b0;
      if (kill) begin
        run     <= 1'b0;
        to_on   <= 1'b0;
        dly_cnt <= '0;
      end else if (start) begin
        run     <= 1'b1;
        idx_q   <= tb_sel;
        to_on   <= to_en;
        tick    <= '0;
        ms_left <= MW'(ms_of(tb_sel));
        dly_cnt <= '0;
      end else if (expire) begin
        run     <= 1'b0;
        to_on   <= 1'b0;
        evt     <= 1'b1;
        dly_cnt <= '0;
      end else begin
        if (to_on) begin
          tick <= tick_wrap ? '0 : tick + TW'(1);
          if (tick_wrap) ms_left <= ms_left - MW'(1);
        end
        if (sample_stb)
          dly_cnt <= (!trig_locked && qd > 0) ? DW'(qd * CYC_PER_QUS) : '0;
        else if (dly_cnt != '0)
          dly_cnt <= trig_locked ? '0 : dly_cnt - DW'(1);
      end
    end
  end

endmodule

// File: rtl/timebase_pacer_chk.sv
module timebase_pacer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] tb_sel,
  input logic       trig_pol,
  input logic       start,
  input logic       abort,
  input logic       sample_stb,
  input logic       keep_sampling,
  input logic       timeout_evt
);

  AST_STB_IN_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> keep_sampling); // R11

  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !keep_sampling); // R3

  AST_RECONF_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_sel != $past(tb_sel) || trig_pol != $past(trig_pol)) |=> !keep_sampling); // R4

  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !abort && $stable(tb_sel) && $stable(trig_pol)) |=> (keep_sampling && !timeout_evt)); // R2

  AST_RISE_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(keep_sampling) |-> $past(start)); // R2

  AST_EVT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> !timeout_evt); // R9

  AST_EVT_ENDS_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |-> !keep_sampling); // R9

endmodule

bind timebase_pacer timebase_pacer_chk u_chk (.*);

// File: tb/timebase_pacer_test.sv
module timebase_pacer_test;
  localparam int CQ = 2;
  localparam int TD = 2;

  logic clk = 0, rst_n = 0, trig_pol = 0, start = 0, to_en = 0;
  logic conv_ready = 0, trig_locked = 0, abort = 0;
  logic [3:0] tb_sel = 0;
  logic sample_stb, keep_sampling, timeout_evt;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  timebase_pacer #(.CYC_PER_QUS(CQ), .TICK_DIV(TD)) uut (
    .clk(clk), .rst_n(rst_n), .tb_sel(tb_sel), .trig_pol(trig_pol), .start(start),
    .to_en(to_en), .conv_ready(conv_ready), .trig_locked(trig_locked), .abort(abort),
    .sample_stb(sample_stb), .keep_sampling(keep_sampling), .timeout_evt(timeout_evt));

  function automatic int hold_qus(input int i);
    int t[12] = '{-1, 3, 14, 33, 81, 178, 465, 946, 1910, 4776, 9570, 19163};
    return (i < 12) ? t[i] : 0;
  endfunction

  function automatic int to_ms(input int i);
    int t[12] = '{50, 50, 50, 100, 100, 100, 150, 250, 500, 1000, 2000, 4500};
    return (i < 12) ? t[i] : 50;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic adv();
    @(posedge clk); #1;
  endtask

  task automatic begin_scan(input int idx, input logic ten);
    adv(); tb_sel = 4'(idx);
    adv(); adv();
    start = 1; to_en = ten;
    adv(); start = 0;
  endtask

  task automatic stop_scan();
    abort = 1; adv(); abort = 0;
  endtask

  initial begin
    #(190000 * 10);
    checks++; fails++;
    $display("FAIL watchdog actual %0d expected %0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) adv();
    #3;
    chk("R1 keep", keep_sampling, 0);
    chk("R1 stb", sample_stb, 0);
    chk("R1 evt", timeout_evt, 0);
    rst_n = 1;

    // R5 free-running ignores conv_ready
    begin_scan(0, 0); conv_ready = 0; #3;
    chk("R2 keep after start", keep_sampling, 1);
    for (int k = 0; k < 6; k++) begin
      chk("R5 free strobe", sample_stb, 1);
      adv(); #3;
    end
    adv(); stop_scan(); #3;
    chk("R3 abort clears", keep_sampling, 0);
    conv_ready = 1; #1;
    chk("R11 no strobe idle", sample_stb, 0);

    // R6 conversion paced, no hold-off
    for (int i = 12; i < 16; i++) begin
      begin_scan(i, 0);
      for (int k = 1; k < 8; k++) begin
        conv_ready = (k % 3 != 0); #3;
        chk("R6 stb follows ready", sample_stb, conv_ready);
        adv();
      end
      stop_scan();
    end

    // R7 hold-off spacing for every delayed entry
    conv_ready = 1;
    for (int i = 1; i < 12; i++) begin
      begin_scan(i, 0); #3;
      chk("R7 first strobe", sample_stb, 1);
      n = 1;
      do begin adv(); #3; n++; end while (!sample_stb && n < 50000);
      chk("R7 strobe spacing", n - 1, hold_qus(i) * CQ + 1);
      adv(); stop_scan();
    end

    // R8 trigger lock drops hold-off
    begin_scan(5, 0); #3;
    chk("R8 first strobe", sample_stb, 1);
    adv(); adv(); trig_locked = 1; #3;
    chk("R8 still holding", sample_stb, 0);
    adv(); #3; chk("R8 hold-off skipped", sample_stb, 1);
    adv(); #3; chk("R8 back-to-back", sample_stb, 1);
    conv_ready = 0; #1; chk("R8 waits ready", sample_stb, 0);
    conv_ready = 1; trig_locked = 0;
    adv(); stop_scan();

    // R9 timeout length for every index
    for (int i = 0; i < 16; i++) begin
      begin_scan(i, 1); #3;
      n = 1;
      while (keep_sampling && n < 20000) begin
        chk("R9 no early evt", timeout_evt, 0);
        adv(); #3; n++;
      end
      chk("R9 timeout length", n - 1, to_ms(i) * TD);
      chk("R9 evt at end", timeout_evt, 1);
      adv(); #3;
      chk("R9 evt single", timeout_evt, 0);
    end

    // R2 restart reloads timer
    begin_scan(0, 1);
    for (int k = 1; k < 60; k++) adv();
    start = 1; adv(); start = 0;
    for (int k = 1; k < 100; k++) adv();
    #3; chk("R2 restart reload keep", keep_sampling, 1);
    adv(); #3; chk("R2 restart reload end", keep_sampling, 0);
    chk("R2 restart evt", timeout_evt, 1);

    // R3 abort beats start
    adv(); abort = 1; start = 1; adv(); abort = 0; start = 0; #3;
    chk("R3 abort wins", keep_sampling, 0);

    // R4 reconfiguration by index and by polarity
    for (int m = 0; m < 2; m++) begin
      begin_scan(3, 1);
      for (int k = 0; k < 5; k++) adv();
      if (m == 0) tb_sel = 4; else trig_pol = ~trig_pol;
      adv(); #3;
      chk("R4 reconfig clears", keep_sampling, 0);
      n = 0;
      for (int k = 0; k < 100 * TD + 20; k++) begin adv(); n += timeout_evt; end
      chk("R4 no timeout after reconfig", n, 0);
    end

    // R10 disarmed timer
    begin_scan(0, 0);
    n = 0;
    for (int k = 0; k < 50 * TD + 40; k++) begin adv(); n += timeout_evt; end
    #3; chk("R10 still running", keep_sampling, 1);
    chk("R10 no evt", n, 0);
    adv(); stop_scan();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule